// File: doc/BRIEF.md
# BCD Time-of-Day and Day Counter with Alarm

This block keeps wall-clock time from a one-second tick supplied by its surroundings. Seconds, minutes and hours are held as two-digit packed BCD values (high digit in bits [7:4], low digit in bits [3:0]). Elapsed days are held as a plain binary count of `DAY_W` bits, 15 by default. Every counting field can be loaded and read through a small byte-wide field-select interface. The same interface also programs a minute, hour and day alarm.

The alarm is checked once per minute, on the tick that returns seconds to 00. Only the fields whose enable bit is set take part in the comparison. A match sets a sticky alarm flag. Software clears the flag by writing 1 to the clear bit of the control field. All four count fields are also driven directly on output ports, so logic nearby can use the time without going through the read path.

Top module: `rtc_calendar`

## Requirements
- R1: While `rst_n` is low, every count field, every alarm value, the enable bits and the alarm flag are zero. After reset, the read of the control field therefore returns 0x00.
- R2: Each tick raises the seconds field by one in packed BCD. A low digit of 9 becomes 0 and carries into the high digit. 0x59 wraps to 0x00 and carries into minutes. With no tick and no write, all count fields hold their value.
- R3: The minutes field counts in BCD from 0x00 to 0x59. It advances only on a carry from seconds. From 0x59 it wraps to 0x00 and carries into hours.
- R4: The hours field counts in BCD from 0x00 to 0x23. It advances only on a carry from minutes. From 0x23 it wraps to 0x00 and carries into days.
- R5: The day field is a DAY_W-bit binary count that advances on a carry from hours. At the default width it wraps from 0x7FFF to 0.
- R6: When `wr_en_i` is high, the field chosen by `wr_sel_i` takes `wr_data_i` at the next clock edge. Select codes: 0 seconds, 1 minutes, 2 hours, 3 day bits [7:0], 4 day bits [14:8] from data[6:0], 5 alarm minute, 6 alarm hour, 7 alarm day [7:0], 8 alarm day [14:8] from data[6:0], 9 control. A write to a count field (codes 0 to 4) discards the tick of that cycle, so no field counts in that cycle.
- R7: `rd_data_o` is a combinational read of the field chosen by `rd_sel_i`, using the same codes. The high day parts read zero-extended. The control field reads as {flag, 4'b0000, day enable, hour enable, minute enable}.
- R8: A tick that takes seconds from 0x59 to 0x00 compares the new minute, hour and day values with the alarm values. The comparison uses only the fields whose enable bit is set: control bit 0 for minute, bit 1 for hour, bit 2 for day. If every enabled field matches, the flag is set at that same clock edge.
- R9: While all three enable bits are zero, the alarm flag is never set.
- R10: The alarm flag stays set until a control write with data bit 7 equal to 1. A control write always loads the enable bits from data[2:0]. If a match and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 4 | Field select for writes |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 4 | Field select for reads |
| rd_data_o | output | 8 | Read data of the selected field |
| sec_o | output | 8 | Seconds, packed BCD |
| min_o | output | 8 | Minutes, packed BCD |
| hour_o | output | 8 | Hours, packed BCD |
| day_o | output | DAY_W | Day count, binary |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
A wrong digit or a lost carry shows on `sec_o` within one tick. A fault in the minute, hour or day chain stays hidden until the next wrap of the field below it, which can take up to 86,400 ticks of free running. For that reason the stimulus loads values just below each wrap point. A bad alarm comparator or a bad enable decode shows on `alarm_o` only at the tick where seconds become 00, and then stays visible because the flag is sticky. The bench compares every port against its reference model on every clock, so any divergence is reported in the cycle where it appears.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [3:0] {
    FSEL_SEC       = 4'd0,
    FSEL_MIN       = 4'd1,
    FSEL_HOUR      = 4'd2,
    FSEL_DAY_LO    = 4'd3,
    FSEL_DAY_HI    = 4'd4,
    FSEL_AL_MIN    = 4'd5,
    FSEL_AL_HOUR   = 4'd6,
    FSEL_AL_DAY_LO = 4'd7,
    FSEL_AL_DAY_HI = 4'd8,
    FSEL_CTRL      = 4'd9
  } fsel_e;

  localparam int NUM_BCD  = 3;
  localparam int EN_W     = 3;
  localparam int EN_MIN   = 0;
  localparam int EN_HOUR  = 1;
  localparam int EN_DAY   = 2;
  localparam int CLR_BIT  = 7;

  // Last value before wrap of BCD field i (0 sec, 1 min, 2 hour)
  function automatic logic [7:0] wrap_of(input int idx);
    return (idx == 2) ? 8'h23 : 8'h59;
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] WRAP_VAL = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o,
  output logic [7:0] nxt_o,
  output logic       carry_o
);

  logic [7:0] cnt_q, cnt_d, inc_val;
  logic       cnt_en, at_wrap;

  always_comb begin
    at_wrap = (cnt_q == WRAP_VAL);
    if (at_wrap)
      inc_val = 8'h00;
    else if (cnt_q[3:0] == 4'd9)
      inc_val = {cnt_q[7:4] + 4'd1, 4'd0};
    else
      inc_val = {cnt_q[7:4], cnt_q[3:0] + 4'd1};

    cnt_en = ld_i | inc_i;
    if (ld_i)
      cnt_d = ld_val_i;
    else if (inc_i)
      cnt_d = inc_val;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= 8'h00;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign val_o   = cnt_q;
  assign nxt_o   = cnt_d;
  assign carry_o = inc_i & at_wrap;

endmodule

// File: rtl/rtc_day_counter.sv
module rtc_day_counter #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [7:0]       ld_val_i,
  output logic [DAY_W-1:0] val_o,
  output logic [DAY_W-1:0] nxt_o
);

  localparam int HI_W = DAY_W - 8;

  logic [DAY_W-1:0] day_q, day_d;
  logic             day_en;

  always_comb begin
    day_d  = day_q;
    day_en = inc_i | ld_lo_i | ld_hi_i;
    if (inc_i)
      day_d = day_q + DAY_W'(1);
    if (ld_lo_i)
      day_d[7:0] = ld_val_i;
    if (ld_hi_i)
      day_d[DAY_W-1:8] = ld_val_i[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      day_q <= '0;
    else if (day_en)
      day_q <= day_d;
  end

  assign val_o = day_q;
  assign nxt_o = day_d;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int DAY_W = 15
) (
  input  logic             eval_i,
  input  logic [7:0]       min_i,
  input  logic [7:0]       hour_i,
  input  logic [DAY_W-1:0] day_i,
  input  logic [7:0]       al_min_i,
  input  logic [7:0]       al_hour_i,
  input  logic [DAY_W-1:0] al_day_i,
  input  logic [2:0]       en_i,
  output logic             hit_o
);

  logic min_ok, hour_ok, day_ok;

  always_comb begin
    min_ok  = !en_i[0] || (min_i  == al_min_i);
    hour_ok = !en_i[1] || (hour_i == al_hour_i);
    day_ok  = !en_i[2] || (day_i  == al_day_i);
    hit_o   = eval_i && (|en_i) && min_ok && hour_ok && day_ok;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic [3:0]       rd_sel_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [DAY_W-1:0] day_o,
  output logic             alarm_o
);

  localparam int HI_W = DAY_W - 8;

  logic time_wr, tick_ok;
  logic [7:0]         bcd_q   [NUM_BCD];
  logic [7:0]         bcd_nxt [NUM_BCD];
  logic [NUM_BCD-1:0] bcd_inc, bcd_carry, bcd_ld;
  logic [DAY_W-1:0]   day_q, day_nxt;

  logic [7:0]       al_min_q, al_min_d, al_hour_q, al_hour_d;
  logic [DAY_W-1:0] al_day_q, al_day_d;
  logic [EN_W-1:0]  al_en_q, al_en_d;
  logic             flag_q, flag_d, al_we, hit, clr;

  assign time_wr = wr_en_i && (wr_sel_i <= 4'(FSEL_DAY_HI));
  assign tick_ok = tick_i && !time_wr;

  for (genvar g = 0; g < NUM_BCD; g++) begin : g_bcd
    if (g == 0) begin : g_first
      assign bcd_inc[g] = tick_ok;
    end else begin : g_chain
      assign bcd_inc[g] = bcd_carry[g-1];
    end
    assign bcd_ld[g] = wr_en_i && (wr_sel_i == 4'(g));

    rtc_bcd_field #(.WRAP_VAL(wrap_of(g))) field_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (bcd_inc[g]),
      .ld_i     (bcd_ld[g]),
      .ld_val_i (wr_data_i),
      .val_o    (bcd_q[g]),
      .nxt_o    (bcd_nxt[g]),
      .carry_o  (bcd_carry[g])
    );
  end

  rtc_day_counter #(.DAY_W(DAY_W)) day_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (bcd_carry[NUM_BCD-1]),
    .ld_lo_i  (wr_en_i && (wr_sel_i == 4'(FSEL_DAY_LO))),
    .ld_hi_i  (wr_en_i && (wr_sel_i == 4'(FSEL_DAY_HI))),
    .ld_val_i (wr_data_i),
    .val_o    (day_q),
    .nxt_o    (day_nxt)
  );

  // Alarm evaluated when seconds wrap to 00, against the updated count
  rtc_alarm_match #(.DAY_W(DAY_W)) match_i (
    .eval_i    (bcd_carry[0]),
    .min_i     (bcd_nxt[1]),
    .hour_i    (bcd_nxt[2]),
    .day_i     (day_nxt),
    .al_min_i  (al_min_q),
    .al_hour_i (al_hour_q),
    .al_day_i  (al_day_q),
    .en_i      (al_en_q),
    .hit_o     (hit)
  );

  always_comb begin
    al_min_d  = al_min_q;
    al_hour_d = al_hour_q;
    al_day_d  = al_day_q;
    al_en_d   = al_en_q;
    clr       = 1'b0;
    if (wr_en_i) begin
      case (wr_sel_i)
        4'(FSEL_AL_MIN):    al_min_d  = wr_data_i;
        4'(FSEL_AL_HOUR):   al_hour_d = wr_data_i;
        4'(FSEL_AL_DAY_LO): al_day_d[7:0] = wr_data_i;
        4'(FSEL_AL_DAY_HI): al_day_d[DAY_W-1:8] = wr_data_i[HI_W-1:0];
        4'(FSEL_CTRL): begin
          al_en_d = wr_data_i[EN_W-1:0];
          clr     = wr_data_i[CLR_BIT];
        end
        default: ;
      endcase
    end
    al_we  = wr_en_i && (wr_sel_i >= 4'(FSEL_AL_MIN)) && (wr_sel_i <= 4'(FSEL_CTRL));
    flag_d = hit ? 1'b1 : (clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_min_q  <= 8'h00;
      al_hour_q <= 8'h00;
      al_day_q  <= '0;
      al_en_q   <= '0;
    end else if (al_we) begin
      al_min_q  <= al_min_d;
      al_hour_q <= al_hour_d;
      al_day_q  <= al_day_d;
      al_en_q   <= al_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= flag_d;
  end

  always_comb begin
    case (rd_sel_i)
      4'(FSEL_SEC):       rd_data_o = bcd_q[0];
      4'(FSEL_MIN):       rd_data_o = bcd_q[1];
      4'(FSEL_HOUR):      rd_data_o = bcd_q[2];
      4'(FSEL_DAY_LO):    rd_data_o = day_q[7:0];
      4'(FSEL_DAY_HI):    rd_data_o = 8'(day_q[DAY_W-1:8]);
      4'(FSEL_AL_MIN):    rd_data_o = al_min_q;
      4'(FSEL_AL_HOUR):   rd_data_o = al_hour_q;
      4'(FSEL_AL_DAY_LO): rd_data_o = al_day_q[7:0];
      4'(FSEL_AL_DAY_HI): rd_data_o = 8'(al_day_q[DAY_W-1:8]);
      4'(FSEL_CTRL):      rd_data_o = {flag_q, 4'b0000, al_en_q};
      default:            rd_data_o = 8'h00;
    endcase
  end

  assign sec_o   = bcd_q[0];
  assign min_o   = bcd_q[1];
  assign hour_o  = bcd_q[2];
  assign day_o   = day_q;
  assign alarm_o = flag_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int DAY_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [3:0]       wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       sec_o,
  input logic [7:0]       min_o,
  input logic [7:0]       hour_o,
  input logic [DAY_W-1:0] day_o,
  input logic             alarm_o,
  input logic [2:0]       al_en
);

  logic time_wr, top_of_day;
  assign time_wr    = wr_en_i && (wr_sel_i <= 4'd4);
  assign top_of_day = tick_i && !time_wr && sec_o == 8'h59 &&
                      min_o == 8'h59 && hour_o == 8'h23;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) &&
                               $stable(hour_o) && $stable(day_o)));

  assert_min_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_wr && sec_o == 8'h59 && min_o == 8'h59) |=>
      (min_o == 8'h00 && sec_o == 8'h00));

  assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    top_of_day |=> (hour_o == 8'h00));

  assert_day_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (top_of_day && day_o == {DAY_W{1'b1}}) |=> (day_o == '0));

  assert_flag_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> (sec_o == 8'h00));

  assert_no_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (al_en == 3'b000 && !alarm_o) |=> !alarm_o);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !(wr_en_i && wr_sel_i == 4'd9 && wr_data_i[7])) |=> alarm_o);

endmodule

bind rtc_calendar rtc_calendar_chk #(.DAY_W(DAY_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .day_o     (day_o),
  .alarm_o   (alarm_o),
  .al_en     (al_en_q)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;

  localparam int DAY_W = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tick_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [3:0]       wr_sel_i = 4'd0;
  logic [7:0]       wr_data_i = 8'd0;
  logic [3:0]       rd_sel_i = 4'd0;
  logic [7:0]       rd_data_o;
  logic [7:0]       sec_o, min_o, hour_o;
  logic [DAY_W-1:0] day_o;
  logic             alarm_o;

  int total = 0;
  int bad   = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar #(.DAY_W(DAY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .day_o(day_o), .alarm_o(alarm_o)
  );

  // reference model state
  int m_sec, m_min, m_hour, m_day, m_amin, m_ahour, m_aday, m_en;
  bit m_flag;

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(input int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 0;
    m_amin = 0; m_ahour = 0; m_aday = 0; m_en = 0; m_flag = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit twr, hit, clr;
      int d;
      d   = int'(wr_data_i);
      twr = wr_en_i && wr_sel_i <= 4'd4;
      hit = 1'b0;
      clr = 1'b0;
      if (tick_i && !twr) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hour++;
            if (m_hour == 24) begin
              m_hour = 0;
              m_day = (m_day + 1) % 32768;
            end
          end
          hit = (m_en != 0) &&
                (!m_en[0] || to_bcd(m_min) == m_amin) &&
                (!m_en[1] || to_bcd(m_hour) == m_ahour) &&
                (!m_en[2] || m_day == m_aday);
        end
      end
      if (wr_en_i) begin
        case (wr_sel_i)
          4'd0: m_sec  = from_bcd(d);
          4'd1: m_min  = from_bcd(d);
          4'd2: m_hour = from_bcd(d);
          4'd3: m_day  = (m_day & 32'h7F00) | d;
          4'd4: m_day  = (m_day & 32'hFF) | ((d & 32'h7F) << 8);
          4'd5: m_amin  = d;
          4'd6: m_ahour = d;
          4'd7: m_aday  = (m_aday & 32'h7F00) | d;
          4'd8: m_aday  = (m_aday & 32'hFF) | ((d & 32'h7F) << 8);
          4'd9: begin m_en = d & 7; clr = d[7]; end
          default: ;
        endcase
      end
      if (hit) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
    end
  end

  function automatic int exp_rd(input int sel);
    case (sel)
      0: return to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: return to_bcd(m_hour);
      3: return m_day & 255;
      4: return m_day >> 8;
      5: return m_amin;
      6: return m_ahour;
      7: return m_aday & 255;
      8: return m_aday >> 8;
      9: return (int'(m_flag) << 7) | m_en;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmp_on && !finished) begin
      chk("R2 seconds", int'(sec_o), to_bcd(m_sec));
      chk("R3 minutes", int'(min_o), to_bcd(m_min));
      chk("R4 hours", int'(hour_o), to_bcd(m_hour));
      chk("R5 days", int'(day_o), m_day);
      chk("R8 alarm flag", int'(alarm_o), int'(m_flag));
      chk("R7 read data", int'(rd_data_o), exp_rd(int'(rd_sel_i)));
    end
  end

  task automatic cyc(input bit t, input bit w, input int s, input int d);
    @(negedge clk);
    tick_i    = t;
    wr_en_i   = w;
    wr_sel_i  = 4'(s);
    wr_data_i = 8'(d);
    rd_sel_i  = 4'($urandom_range(0, 9));
  endtask

  task automatic settle();
    cyc(0, 0, 0, 0);
    @(negedge clk);
    #2;
  endtask

  function automatic int rnd_bcd(input int hi);
    return to_bcd(int'($urandom_range(0, hi)));
  endfunction

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    #2;
    chk("R1 sec", int'(sec_o), 0);
    chk("R1 day", int'(day_o), 0);
    chk("R1 flag", int'(alarm_o), 0);
    rd_sel_i = 4'd9; #0.5;
    chk("R1 ctrl read", int'(rd_data_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R6 loads, then R4/R5 full-day and day-counter wrap
    cyc(0, 1, 0, 8'h58); cyc(0, 1, 1, 8'h59); cyc(0, 1, 2, 8'h23);
    cyc(0, 1, 3, 8'hFF); cyc(0, 1, 4, 8'hFF);
    settle();
    chk("R6 loaded hour", int'(hour_o), 8'h23);
    chk("R6 loaded day", int'(day_o), 32'h7FFF);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    settle();
    chk("R4 hour wrap", int'(hour_o), 0);
    chk("R5 day wrap", int'(day_o), 0);

    // R8 minute alarm
    cyc(0, 1, 5, 8'h01); cyc(0, 1, 9, 8'h01);
    cyc(0, 1, 0, 8'h59); cyc(0, 1, 1, 8'h00);
    cyc(1, 0, 0, 0);
    settle();
    chk("R8 minute match sets flag", int'(alarm_o), 1);
    repeat (5) cyc(1, 0, 0, 0);
    settle();
    chk("R10 flag sticky", int'(alarm_o), 1);
    cyc(0, 1, 9, 8'h81);
    settle();
    chk("R10 clear by write", int'(alarm_o), 0);
    rd_sel_i = 4'd9; #0.5;
    chk("R10 enables kept", int'(rd_data_o), 8'h01);

    // R9 all enables off, values matching
    cyc(0, 1, 9, 8'h80);
    cyc(0, 1, 5, 8'h01); cyc(0, 1, 6, 8'h00); cyc(0, 1, 7, 8'h00); cyc(0, 1, 8, 8'h00);
    cyc(0, 1, 2, 8'h00); cyc(0, 1, 1, 8'h00); cyc(0, 1, 0, 8'h59);
    cyc(0, 1, 3, 8'h00); cyc(0, 1, 4, 8'h00);
    cyc(1, 0, 0, 0);
    settle();
    chk("R9 no enable no flag", int'(alarm_o), 0);

    // R8 hour + day alarm
    cyc(0, 1, 6, 8'h05); cyc(0, 1, 7, 8'h34); cyc(0, 1, 8, 8'h12); cyc(0, 1, 9, 8'h06);
    cyc(0, 1, 2, 8'h04); cyc(0, 1, 1, 8'h59); cyc(0, 1, 0, 8'h59);
    cyc(0, 1, 3, 8'h34); cyc(0, 1, 4, 8'h12);
    cyc(1, 0, 0, 0);
    settle();
    chk("R8 hour+day match", int'(alarm_o), 1);

    // R6 time write discards tick
    cyc(0, 1, 0, 8'h10);
    cyc(1, 1, 0, 8'h20);
    settle();
    chk("R6 write beats tick", int'(sec_o), 8'h20);

    // R10 set wins over clear in the same cycle
    cyc(0, 1, 9, 8'h81); cyc(0, 1, 5, 8'h01); cyc(0, 1, 1, 8'h00); cyc(0, 1, 0, 8'h59);
    cyc(1, 1, 9, 8'h81);
    settle();
    chk("R10 set beats clear", int'(alarm_o), 1);

    // random traffic, compared every clock
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 49) == 0) begin
        int s, d;
        s = int'($urandom_range(0, 9));
        case (s)
          0, 1, 5: d = rnd_bcd(59);
          2, 6:    d = rnd_bcd(23);
          9:       d = int'($urandom_range(0, 255)) & 8'h87;
          default: d = int'($urandom_range(0, 255));
        endcase
        if (s == 1 && $urandom_range(0, 1) == 1) d = 8'h59;
        if (s == 2 && $urandom_range(0, 1) == 1) d = 8'h23;
        cyc(int'($urandom_range(0, 1)) == 1, 1, s, d);
      end else begin
        cyc($urandom_range(0, 3) != 0, 0, 0, 0);
      end
    end
    settle();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule